// File: doc/BRIEF.md
# Auto-Negotiation Page Status Register File

This block sits between the auto-negotiation page decoder of an Ethernet PHY and its management register port. Every page the decoder recovers is reported to it as a single-cycle event that carries the 16-bit page word and a flag telling base pages from next pages. The block holds back a base page until the same word has arrived three times in a row. Only then does it latch that word as the link partner's ability word. Next pages are stored only while both ends have said they can exchange them.

Software sees three sticky status flags in the status register. The first records that a page was taken in. The second records that the partner offered next pages. The third shows whether the newest page taken in was the base page. The flags clear when the status register is read, and also when a new negotiation starts. A second copy of the page-taken flag sits in a vendor-area register.

Software loads the outgoing next page through a write. A "loaded" flag then offers that word to the transmit side, which takes it with a one-cycle pulse. Register reads are combinational on the address. The read strobe only triggers the clear-on-read side effects.

Top module: `an_page_regs`

## Requirements
- R1: After reset every readable register returns 0 and `np_tx_ready` is low.
- R2: A base page is accepted when the third consecutive identical base-page word arrives, with `MATCH_N` = 3. On acceptance the word is latched into register 5, and status register 6 gets bit 1 (page taken) and bit 5 (base page) set. One or two copies leave register 5 and register 6 unchanged.
- R3: A base word that differs from the held reference restarts the run at one copy, with the new word as the reference. A run that has already been accepted is not accepted again while identical copies keep arriving.
- R4: A next page (`pg_valid` with `pg_is_base` low) is stored into register 8 and sets register 6 bit 1 only when `local_np` is high and the partner's next-page ability was latched high at the last base acceptance. Otherwise register 8 and register 6 bit 1 do not change.
- R5: Register 6 bit 1 stays set until register 6 is read. The read returns the set value and clears the bit. Register 16 bit 1 shows the same flag and is cleared by the register 6 read. Reading register 16 clears nothing.
- R6: A page event in the same cycle as a register 6 read leaves bit 1 set after the read.
- R7: Register 6 bit 2 is set when a base page is accepted while `partner_np` is high. It stays set until register 6 is read or a new negotiation starts.
- R8: Register 6 bit 5 is set by a base acceptance and cleared by an accepted next page. A read does not clear it.
- R9: A `neg_restart` pulse clears register 6 bits 1, 2 and 5, register 16 bit 1, the match run and the latched partner ability. A page event in the same cycle is dropped.
- R10: Writing register 7 sets the loaded flag. `np_tx_ready` equals loaded AND the next-page enable of R4, and `np_tx_word` shows register 7. `np_take` while ready clears loaded. A write in the same cycle as a take leaves loaded set with the new word.
- R11: Writes to any address other than 7 have no effect. Reads of unmapped addresses return 0. Register 7 reads back the last written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | AW (5) | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers clear-on-read) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| pg_valid | input | 1 | Page received event from the page decoder |
| pg_is_base | input | 1 | The event carries a base page |
| pg_word | input | 16 | Received page word |
| partner_np | input | 1 | Partner advertises next-page ability |
| local_np | input | 1 | Local side advertises next-page ability |
| neg_restart | input | 1 | New negotiation starts (pulse) |
| np_take | input | 1 | Transmit side consumes the loaded next page |
| np_tx_word | output | 16 | Outgoing next-page word |
| np_tx_ready | output | 1 | A next page is loaded and next-page exchange is enabled |

## Verification
The assertions assume that all inputs are synchronous to `clk`, and that `pg_is_base`, `pg_word` and `partner_np` matter only in a cycle where `pg_valid` is high. The one-acceptance-per-run property also assumes `MATCH_N` is at least 2. The stimulus drives at most one event per operation and returns every strobe to idle between operations. Page runs are separated by idle cycles, which the match logic must tolerate. The collisions the requirements name (read with event, restart with event, write with take) are the only places where several strobes are raised together.

// File: rtl/an_page_pkg.sv
package an_page_pkg;

    localparam int unsigned DW = 16;

    // register map
    localparam int unsigned ADDR_PARTNER = 5;
    localparam int unsigned ADDR_STAT    = 6;
    localparam int unsigned ADDR_NPTX    = 7;
    localparam int unsigned ADDR_NPRX    = 8;
    localparam int unsigned ADDR_MIRROR  = 16;

    // status bit positions
    localparam int unsigned ST_RCVD_BIT   = 1;
    localparam int unsigned ST_NPABLE_BIT = 2;
    localparam int unsigned ST_BASE_BIT   = 5;
    localparam int unsigned MIRROR_BIT    = 1;

    typedef logic [DW-1:0] word_t;

    typedef struct packed {
        logic  valid;
        logic  is_base;
        word_t word;
    } page_evt_t;

    typedef struct packed {
        logic base_flag;
        logic np_able;
        logic pg_rcvd;
    } stat_t;

    function automatic word_t pack_status(stat_t s);
        word_t w;
        w = '0;
        w[ST_RCVD_BIT]   = s.pg_rcvd;
        w[ST_NPABLE_BIT] = s.np_able;
        w[ST_BASE_BIT]   = s.base_flag;
        return w;
    endfunction

    function automatic word_t pack_mirror(stat_t s);
        word_t w;
        w = '0;
        w[MIRROR_BIT] = s.pg_rcvd;
        return w;
    endfunction

endpackage

// File: rtl/an_base_match.sv
module an_base_match
    import an_page_pkg::*;
#(
    parameter int unsigned MATCH_N = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  evt,
    input  word_t word,
    output logic  accept,
    output word_t acc_word
);
    localparam int unsigned CW = $clog2(MATCH_N + 1);

    logic [CW-1:0] cnt_q, cnt_nxt;
    word_t         ref_q;
    logic          hit;

    always_comb begin
        hit = (cnt_q != '0) && (word == ref_q);
        if (hit)
            cnt_nxt = (cnt_q == CW'(MATCH_N)) ? cnt_q : cnt_q + 1'b1;
        else
            cnt_nxt = CW'(1);
        accept   = evt && !restart && (cnt_nxt == CW'(MATCH_N)) && (cnt_q != CW'(MATCH_N));
        acc_word = word;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
            ref_q <= '0;
        end else if (evt) begin
            cnt_q <= cnt_nxt;
            ref_q <= word;
        end
    end

    AST_ONE_ACCEPT_PER_RUN: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept); // R3

endmodule

// File: rtl/an_page_status.sv
module an_page_status
    import an_page_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  rd_clr,
    input  logic  base_acc,
    input  logic  partner_np,
    input  logic  np_rcv,
    output stat_t st
);
    stat_t st_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st_q <= '0;
        end else begin
            if (base_acc || np_rcv)
                st_q.pg_rcvd <= 1'b1;
            else if (rd_clr)
                st_q.pg_rcvd <= 1'b0;

            if (base_acc && partner_np)
                st_q.np_able <= 1'b1;
            else if (rd_clr)
                st_q.np_able <= 1'b0;

            if (base_acc)
                st_q.base_flag <= 1'b1;
            else if (np_rcv)
                st_q.base_flag <= 1'b0;
        end
    end

    assign st = st_q;

    AST_RCVD_STICKY: assert property (@(posedge clk) disable iff (rst)
        st.pg_rcvd && !rd_clr && !restart |=> st.pg_rcvd); // R5
    AST_RCVD_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rd_clr && !base_acc && !np_rcv |=> !st.pg_rcvd); // R5
    AST_EVT_BEATS_READ: assert property (@(posedge clk) disable iff (rst)
        rd_clr && np_rcv && !restart |=> st.pg_rcvd); // R6
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart |=> (st == '0)); // R9
    AST_BASE_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !base_acc && !np_rcv && !restart |=> $stable(st.base_flag)); // R8

endmodule

// File: rtl/an_np_regs.sv
module an_np_regs
    import an_page_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_wr,
    input  word_t tx_wdata,
    input  logic  np_en,
    input  logic  take,
    input  logic  rx_we,
    input  word_t rx_word_in,
    output word_t tx_word,
    output logic  tx_ready,
    output word_t rx_word
);
    word_t tx_q, rx_q;
    logic  loaded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q     <= '0;
            rx_q     <= '0;
            loaded_q <= 1'b0;
        end else begin
            if (tx_wr) begin
                tx_q     <= tx_wdata;
                loaded_q <= 1'b1;
            end else if (take && tx_ready) begin
                loaded_q <= 1'b0;
            end
            if (rx_we)
                rx_q <= rx_word_in;
        end
    end

    assign tx_word  = tx_q;
    assign tx_ready = loaded_q && np_en;
    assign rx_word  = rx_q;

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> loaded_q); // R10
    AST_TAKE_DRAINS: assert property (@(posedge clk) disable iff (rst)
        take && tx_ready && !tx_wr |=> !loaded_q); // R10
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tx_wr |=> $stable(tx_q)); // R11

endmodule

// File: rtl/an_page_regs.sv
module an_page_regs
    import an_page_pkg::*;
#(
    parameter int unsigned AW      = 5,
    parameter int unsigned MATCH_N = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          pg_valid,
    input  logic          pg_is_base,
    input  logic [15:0]   pg_word,
    input  logic          partner_np,
    input  logic          local_np,
    input  logic          neg_restart,
    input  logic          np_take,
    output logic [15:0]   np_tx_word,
    output logic          np_tx_ready
);
    page_evt_t evt;
    stat_t     st;
    word_t     acc_word, partner_q, rx_word;
    logic      base_acc, partner_np_q, np_en, np_rx_we, rd_stat, wr_nptx;

    always_comb begin
        evt.valid   = pg_valid;
        evt.is_base = pg_is_base;
        evt.word    = pg_word;
    end

    assign rd_stat  = reg_rd && (reg_addr == AW'(ADDR_STAT));
    assign wr_nptx  = reg_wr && (reg_addr == AW'(ADDR_NPTX));
    assign np_en    = local_np && partner_np_q;
    assign np_rx_we = evt.valid && !evt.is_base && np_en && !neg_restart;

    an_base_match #(.MATCH_N(MATCH_N)) u_match (
        .clk      (clk),
        .rst      (rst),
        .restart  (neg_restart),
        .evt      (evt.valid && evt.is_base),
        .word     (evt.word),
        .accept   (base_acc),
        .acc_word (acc_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            partner_q    <= '0;
            partner_np_q <= 1'b0;
        end else if (neg_restart) begin
            partner_np_q <= 1'b0;
        end else if (base_acc) begin
            partner_q    <= acc_word;
            partner_np_q <= partner_np;
        end
    end

    an_page_status u_status (
        .clk        (clk),
        .rst        (rst),
        .restart    (neg_restart),
        .rd_clr     (rd_stat),
        .base_acc   (base_acc),
        .partner_np (partner_np),
        .np_rcv     (np_rx_we),
        .st         (st)
    );

    an_np_regs u_np (
        .clk        (clk),
        .rst        (rst),
        .tx_wr      (wr_nptx),
        .tx_wdata   (reg_wdata),
        .np_en      (np_en),
        .take       (np_take),
        .rx_we      (np_rx_we),
        .rx_word_in (evt.word),
        .tx_word    (np_tx_word),
        .tx_ready   (np_tx_ready),
        .rx_word    (rx_word)
    );

    always_comb begin
        unique case (reg_addr)
            AW'(ADDR_PARTNER): reg_rdata = partner_q;
            AW'(ADDR_STAT):    reg_rdata = pack_status(st);
            AW'(ADDR_NPTX):    reg_rdata = np_tx_word;
            AW'(ADDR_NPRX):    reg_rdata = rx_word;
            AW'(ADDR_MIRROR):  reg_rdata = pack_mirror(st);
            default:           reg_rdata = '0;
        endcase
    end

    AST_NP_GATED: assert property (@(posedge clk) disable iff (rst)
        pg_valid && !pg_is_base && !np_en |=> $stable(rx_word)); // R4
    AST_PARTNER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !base_acc |=> $stable(partner_q)); // R2
    AST_PARTNER_ABLE_CLR: assert property (@(posedge clk) disable iff (rst)
        neg_restart |=> !np_tx_ready); // R9

endmodule

// File: tb/an_page_regs_tb.sv
`timescale 1ns/100ps
module an_page_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pg_valid = 1'b0, pg_is_base = 1'b0;
    logic [15:0] pg_word = '0;
    logic        partner_np = 1'b0, local_np = 1'b0, neg_restart = 1'b0, np_take = 1'b0;
    logic [15:0] np_tx_word;
    logic        np_tx_ready;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    an_page_regs u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pg_valid(pg_valid),
        .pg_is_base(pg_is_base), .pg_word(pg_word), .partner_np(partner_np),
        .local_np(local_np), .neg_restart(neg_restart), .np_take(np_take),
        .np_tx_word(np_tx_word), .np_tx_ready(np_tx_ready)
    );

    function automatic logic [15:0] sw(input logic b5, input logic b2, input logic b1);
        return (16'(b5) << 5) | (16'(b2) << 2) | (16'(b1) << 1);
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one operation: inputs held for one clock, read data sampled before the edge
    task automatic op(input logic pv, input logic pb, input logic [15:0] pw,
                      input logic rd, input logic wr, input logic [4:0] a,
                      input logic [15:0] wd, input logic rs, input logic tk,
                      output logic [15:0] rdv);
        @(posedge clk); #1;
        pg_valid = pv; pg_is_base = pb; pg_word = pw;
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        neg_restart = rs; np_take = tk;
        #1 rdv = reg_rdata;
        @(posedge clk); #1;
        pg_valid = 0; pg_is_base = 0; reg_rd = 0; reg_wr = 0; neg_restart = 0; np_take = 0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5 v = reg_rdata;
    endtask

    task automatic page(input logic [15:0] w, input logic base);
        logic [15:0] d;
        op(1, base, w, 0, 0, 0, 0, 0, 0, d);
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        op(0, 0, 0, 1, 0, a, 0, 0, 0, v);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] wd);
        logic [15:0] d;
        op(0, 0, 0, 0, 1, a, wd, 0, 0, d);
    endtask

    task automatic restart();
        logic [15:0] d;
        op(0, 0, 0, 0, 0, 0, 0, 1, 0, d);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v, exp5, exp8;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        foreach (v[i]) ; // no-op keeps v declared use-free
        peek(5, v);  chk(v, 0, "R1 reg5");
        peek(6, v);  chk(v, 0, "R1 reg6");
        peek(7, v);  chk(v, 0, "R1 reg7");
        peek(8, v);  chk(v, 0, "R1 reg8");
        peek(16, v); chk(v, 0, "R1 reg16");
        chk(16'(np_tx_ready), 0, "R1 ready");

        // R2 / R7 / R8 / R9: sweep run length 1..4, partner ability alternating
        exp5 = 0;
        for (int n = 1; n <= 4; n++) begin
            logic acc, pn;
            restart();
            pn = n[0];
            partner_np = pn;
            for (int k = 0; k < n; k++) page(16'h1000 + 16'(n), 1);
            acc = (n >= 3);
            if (acc) exp5 = 16'h1000 + 16'(n);
            peek(5, v); chk(v, exp5, "R2 partner word vs run length");
            peek(6, v); chk(v, sw(acc, acc & pn, acc), "R2 R7 R8 status vs run length");
            restart();
            peek(6, v);  chk(v, 0, "R9 status after restart");
            peek(16, v); chk(v, 0, "R9 mirror after restart");
        end

        // R3: mismatch restarts the run with the new word
        partner_np = 0;
        page(16'h00AA, 1); page(16'h00AA, 1); page(16'h00BB, 1); page(16'h00BB, 1);
        peek(5, v); chk(v, exp5, "R3 no accept after A A B B");
        page(16'h00BB, 1);
        peek(5, v); chk(v, 16'h00BB, "R3 accept on third B");
        rd(6, v);
        page(16'h00BB, 1);
        peek(6, v); chk(v, sw(1, 0, 0), "R3 no re-accept of same run");

        // R4 / R8 / R10: next-page gating sweep
        exp8 = 0;
        for (int ln = 0; ln < 2; ln++) begin
            for (int pn = 0; pn < 2; pn++) begin
                logic en;
                logic [15:0] nw;
                restart();
                local_np = ln[0]; partner_np = pn[0];
                for (int k = 0; k < 3; k++) page(16'h4321, 1);
                rd(6, v);
                nw = 16'hA000 + 16'(ln * 2 + pn);
                en = ln[0] & pn[0];
                page(nw, 0);
                if (en) exp8 = nw;
                peek(8, v); chk(v, exp8, "R4 reg8 gating");
                peek(6, v); chk(v, sw(!en, 0, en), "R4 R8 status after next page");
                wr(7, 16'h7000 + nw);
                chk(16'(np_tx_ready), 16'(en), "R10 ready follows enable");
            end
        end

        // R10: take and write/take collision
        chk(np_tx_word, 16'h7000 + 16'hA003, "R10 tx word");
        op(0, 0, 0, 0, 0, 0, 0, 0, 1, v);
        chk(16'(np_tx_ready), 0, "R10 take clears loaded");
        wr(7, 16'h1111);
        op(0, 0, 0, 0, 1, 7, 16'h2222, 0, 1, v);
        chk(16'(np_tx_ready), 1, "R10 write beats take");
        chk(np_tx_word, 16'h2222, "R10 new word after collision");

        // R5 / R6: sticky, mirror, read collision
        repeat (5) @(posedge clk);
        peek(6, v);  chk(v, sw(0, 0, 1), "R5 bit1 sticky over idle");
        peek(16, v); chk(v, 16'h0002, "R5 mirror set");
        rd(16, v);
        peek(16, v); chk(v, 16'h0002, "R5 mirror read does not clear");
        op(1, 0, 16'h0C0C, 1, 0, 6, 0, 0, 0, v);
        chk(v, sw(0, 0, 1), "R6 read data during collision");
        peek(6, v); chk(v, sw(0, 0, 1), "R6 event beats read");
        rd(6, v);   chk(v, sw(0, 0, 1), "R5 read returns set value");
        peek(6, v);  chk(v, 0, "R5 read clears bit1");
        peek(16, v); chk(v, 0, "R5 mirror cleared by status read");
        op(1, 0, 16'h0D0D, 1, 0, 6, 0, 0, 0, v);
        chk(v, 0, "R6 read data with clear flag");
        peek(6, v); chk(v, sw(0, 0, 1), "R6 event sets during read");
        peek(8, v); chk(v, 16'h0D0D, "R4 reg8 updated when enabled");

        // R7: np-able sticky, read clears it, restart clears it
        restart();
        partner_np = 1;
        for (int k = 0; k < 3; k++) page(16'h5555, 1);
        repeat (3) @(posedge clk);
        peek(6, v); chk(v, sw(1, 1, 1), "R7 bit2 set and held");
        rd(6, v);   chk(v, sw(1, 1, 1), "R7 read value");
        peek(6, v); chk(v, sw(1, 0, 0), "R7 R8 read clears bit2 not bit5");
        for (int k = 0; k < 3; k++) page(16'h6666, 1);
        peek(6, v); chk(v, sw(1, 1, 1), "R7 reaccept new run");
        restart();
        peek(6, v); chk(v, 0, "R9 restart clears bit2");
        page(16'h0E0E, 0);
        peek(8, v); chk(v, 16'h0D0D, "R9 enable lost after restart");

        // R9: restart same cycle as page event
        for (int k = 0; k < 3; k++) page(16'h7777, 1);
        rd(6, v);
        op(1, 0, 16'h0F0F, 0, 0, 0, 0, 1, 0, v);
        peek(8, v); chk(v, 16'h0D0D, "R9 event dropped on restart");
        peek(6, v); chk(v, 0, "R9 status clear on restart collision");

        // R11: writes elsewhere ignored, unmapped reads zero
        wr(8, 16'hDEAD); wr(6, 16'hFFFF); wr(5, 16'hBEEF); wr(16, 16'hFFFF);
        peek(8, v);  chk(v, 16'h0D0D, "R11 reg8 not writable");
        peek(6, v);  chk(v, 0, "R11 reg6 not writable");
        peek(5, v);  chk(v, 16'h7777, "R11 reg5 not writable");
        peek(16, v); chk(v, 0, "R11 reg16 not writable");
        peek(3, v);  chk(v, 0, "R11 unmapped read");
        peek(7, v);  chk(v, 16'h2222, "R11 reg7 readback");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule